// File: doc/BRIEF.md
# Bandwidth-Limited In-Order Retire Controller

This block decides, every clock, which of the oldest entries of a reorder buffer leave it. The buffer presents a window of `W` head entries in program order, slot 0 being the oldest, each with its status flags and a 16-bit sequence number. The controller walks the window from slot 0 and, within the same cycle, raises a commit or a drop strobe per slot so the buffer can pop those entries at the next edge. The walk stops at the first entry that is absent or cannot leave yet, so younger entries never overtake an older one.

Entries that have been squashed are dropped without being committed. Entries that have not executed but must run non-speculatively (serialising operations, barriers) or uncached (loads) are turned into a request back toward the execute stage, with the entry's sequence number. A faulting entry becomes a trap request and blocks all retirement until the trap handler acknowledges. The block also keeps the sequence number of the youngest committed entry and two saturating counters: committed instructions and cycles that used the full retire bandwidth.

Top module: `retire_ctl`

## Requirements
- R1: Retirement is in order: the set of slots with a commit or drop strobe is always a contiguous run starting at slot 0, and the walk stops at the first slot whose valid flag is low, at an unexecuted plain entry, or at any entry that is held back by R3, R4 or R5.
- R2: A valid squashed entry is dropped (drop strobe, no commit strobe), does not count toward the per-cycle commit total, does not make a later entry "not first", and the walk continues past it; any drop or commit raises the buffer-changed strobe.
- R3: An unexecuted entry flagged non-speculative or barrier produces, one cycle later, a request pulse carrying its sequence number with the uncached bit 0, but only when no entry was committed earlier in the same cycle and the store-pending input is low; otherwise no request is made. In both cases the walk stops there.
- R4: An unexecuted load (not flagged non-speculative or barrier) produces, one cycle later, a request pulse with its sequence number and the uncached bit 1, regardless of its slot; the walk stops there.
- R5: An executed entry with the fault flag is not committed; when it is the first commit candidate of the cycle and stores are not pending, a one-cycle trap request follows and the trap-pending state is set; otherwise it waits. While trap-pending is set no slot commits or drops, and the trap-done input clears it.
- R6: The done sequence number output takes, one cycle later, the sequence number of the youngest entry committed in a cycle, and holds its value in cycles with no commit.
- R7: An entry flagged as not-counted (no-op or instruction prefetch) commits normally but is left out of the committed-instruction counter.
- R8: The bandwidth counter increases by one after every cycle in which exactly `W` entries commit.
- R9: Both counters saturate at all ones instead of wrapping.
- R10: After reset all registered outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_pend | input | 1 | Stores are still waiting to write back |
| trap_done | input | 1 | Trap handler finished; clears trap-pending |
| hd_valid | input | W | Slot holds an entry |
| hd_squashed | input | W | Entry was squashed |
| hd_done | input | W | Entry has executed |
| hd_nonspec | input | W | Entry must execute non-speculatively |
| hd_barrier | input | W | Entry is a memory or write barrier |
| hd_load | input | W | Entry is a load |
| hd_fault | input | W | Entry carries a fault |
| hd_nocount | input | W | Entry is a no-op or instruction prefetch |
| hd_seq | input | W*SEQ_W | Sequence numbers, slot i at bits i*SEQ_W upward |
| rt_commit | output | W | Slot commits this cycle |
| rt_drop | output | W | Slot is dropped as squashed this cycle |
| rob_chg | output | 1 | Buffer occupancy changes this cycle |
| done_seq | output | SEQ_W | Youngest committed sequence number |
| xreq_vld | output | 1 | Execute request pulse |
| xreq_seq | output | SEQ_W | Sequence number of the requested entry |
| xreq_uncached | output | 1 | Request is an uncached load |
| trap_req | output | 1 | Trap request pulse |
| trap_pend | output | 1 | Trap pending; retirement blocked |
| inst_cnt | output | CNT_W | Saturating committed-instruction count |
| bw_cnt | output | CNT_W | Saturating full-bandwidth cycle count |

## Verification
A wrong walk shows immediately on the same-cycle strobes: a hole in the retire run, a commit beyond a blocked slot, or a drop missing. Errors in the first-candidate rule for barriers and faults appear one cycle later as a missing or extra request or trap pulse, while a stuck trap-pending state shows as silent strobes on every following cycle. Counter mistakes accumulate, so the bench compares both counters after every cycle and drives them into saturation.

// File: rtl/retire_ctl.sv
module retire_ctl #(
  parameter int W     = 4,
  parameter int SEQ_W = 16,
  parameter int CNT_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               st_pend,
  input  logic               trap_done,
  input  logic [W-1:0]       hd_valid,
  input  logic [W-1:0]       hd_squashed,
  input  logic [W-1:0]       hd_done,
  input  logic [W-1:0]       hd_nonspec,
  input  logic [W-1:0]       hd_barrier,
  input  logic [W-1:0]       hd_load,
  input  logic [W-1:0]       hd_fault,
  input  logic [W-1:0]       hd_nocount,
  input  logic [W*SEQ_W-1:0] hd_seq,
  output logic [W-1:0]       rt_commit,
  output logic [W-1:0]       rt_drop,
  output logic               rob_chg,
  output logic [SEQ_W-1:0]   done_seq,
  output logic               xreq_vld,
  output logic [SEQ_W-1:0]   xreq_seq,
  output logic               xreq_uncached,
  output logic               trap_req,
  output logic               trap_pend,
  output logic [CNT_W-1:0]   inst_cnt,
  output logic [CNT_W-1:0]   bw_cnt
);
  localparam int NW = $clog2(W + 1);
  localparam logic [NW-1:0] FULL = NW'(W);

  logic             stop;
  logic [NW-1:0]    ncom, nadd;
  logic [SEQ_W-1:0] seq_i, last_seq;
  logic             xv, xunc, tset;
  logic [SEQ_W-1:0] xs;
  logic [CNT_W:0]   isum, bsum;

  always_comb begin
    rt_commit = '0;
    rt_drop   = '0;
    ncom      = '0;
    nadd      = '0;
    last_seq  = done_seq;
    xv        = 1'b0;
    xs        = '0;
    xunc      = 1'b0;
    tset      = 1'b0;
    seq_i     = '0;
    stop      = trap_pend;
    for (int i = 0; i < W; i++) begin
      seq_i = hd_seq[i*SEQ_W +: SEQ_W];
      if (!stop) begin
        if (!hd_valid[i]) begin
          stop = 1'b1;
        end else if (hd_squashed[i]) begin
          rt_drop[i] = 1'b1;
        end else if (!hd_done[i]) begin
          stop = 1'b1;
          if (hd_nonspec[i] || hd_barrier[i]) begin
            if (ncom == '0 && !st_pend) begin
              xv = 1'b1;
              xs = seq_i;
            end
          end else if (hd_load[i]) begin
            xv   = 1'b1;
            xs   = seq_i;
            xunc = 1'b1;
          end
        end else if (hd_fault[i]) begin
          stop = 1'b1;
          if (ncom == '0 && !st_pend) tset = 1'b1;
        end else begin
          rt_commit[i] = 1'b1;
          ncom         = ncom + 1'b1;
          last_seq     = seq_i;
          if (!hd_nocount[i]) nadd = nadd + 1'b1;
        end
      end
    end
  end

  assign rob_chg = |(rt_commit | rt_drop);
  assign isum    = {1'b0, inst_cnt} + (CNT_W+1)'(nadd);
  assign bsum    = {1'b0, bw_cnt} + (CNT_W+1)'(ncom == FULL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_seq      <= '0;
      xreq_vld      <= 1'b0;
      xreq_seq      <= '0;
      xreq_uncached <= 1'b0;
      trap_req      <= 1'b0;
      trap_pend     <= 1'b0;
      inst_cnt      <= '0;
      bw_cnt        <= '0;
    end else begin
      done_seq      <= last_seq;
      xreq_vld      <= xv;
      xreq_seq      <= xs;
      xreq_uncached <= xunc;
      trap_req      <= tset;
      if (tset) trap_pend <= 1'b1;
      else if (trap_done) trap_pend <= 1'b0;
      inst_cnt      <= isum[CNT_W] ? '1 : isum[CNT_W-1:0];
      bw_cnt        <= bsum[CNT_W] ? '1 : bsum[CNT_W-1:0];
    end
  end

  // R1
  in_order_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((((rt_commit | rt_drop) + 1'b1) & (rt_commit | rt_drop)) == '0));
  // R5
  trap_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_pend |-> (rt_commit == '0 && rt_drop == '0));
  // R5
  trap_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trap_pend) |-> trap_req);
  // R3
  req_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(xreq_vld && trap_req));
  // R8
  bw_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bw_cnt == $past(bw_cnt)) || (bw_cnt == $past(bw_cnt) + 1'b1));
  // R9
  inst_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inst_cnt >= $past(inst_cnt));
endmodule

// File: tb/test_retire_ctl.sv
module test_retire_ctl;
  localparam int W = 4, SEQ_W = 16, CNT_W = 6;
  localparam logic [CNT_W-1:0] MAXC = '1;

  logic clk = 0, rst_n = 0, st_pend = 0, trap_done = 0;
  logic [W-1:0] hv = 0, hs = 0, hd = 0, hn = 0, hb = 0, hl = 0, hf = 0, hc = 0;
  logic [W*SEQ_W-1:0] hq = 0;
  logic [W-1:0] rt_commit, rt_drop;
  logic rob_chg, xreq_vld, xreq_uncached, trap_req, trap_pend;
  logic [SEQ_W-1:0] done_seq, xreq_seq;
  logic [CNT_W-1:0] inst_cnt, bw_cnt;

  always #5 clk = ~clk;

  retire_ctl #(.W(W), .SEQ_W(SEQ_W), .CNT_W(CNT_W)) i_retire_ctl (
    .clk(clk), .rst_n(rst_n), .st_pend(st_pend), .trap_done(trap_done),
    .hd_valid(hv), .hd_squashed(hs), .hd_done(hd), .hd_nonspec(hn),
    .hd_barrier(hb), .hd_load(hl), .hd_fault(hf), .hd_nocount(hc), .hd_seq(hq),
    .rt_commit(rt_commit), .rt_drop(rt_drop), .rob_chg(rob_chg),
    .done_seq(done_seq), .xreq_vld(xreq_vld), .xreq_seq(xreq_seq),
    .xreq_uncached(xreq_uncached), .trap_req(trap_req), .trap_pend(trap_pend),
    .inst_cnt(inst_cnt), .bw_cnt(bw_cnt));

  typedef struct packed {
    logic [SEQ_W-1:0] dseq;
    logic xv; logic [SEQ_W-1:0] xs; logic xu;
    logic tr; logic tp;
    logic [CNT_W-1:0] ic, bc;
    logic [7:0] tag;
  } exp_t;

  exp_t q[$];
  int nchk = 0, nbad = 0;
  logic [SEQ_W-1:0] m_done = 0;
  logic m_pend = 0;
  logic [CNT_W-1:0] m_ic = 0, m_bc = 0;

  task automatic ck(string r, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", r, act, exp, $time);
    end
  endtask

  // one cycle: drive, model, check strobes, queue registered expectations
  task automatic cyc(string r, logic [W-1:0] v, s, d, ns, b, l, f, nc,
                     logic [SEQ_W-1:0] base, logic sp, logic td);
    logic [W-1:0] ec = 0, ed = 0;
    int n = 0, add = 0;
    logic stp = m_pend, xv = 0, xu = 0, tr = 0;
    logic [SEQ_W-1:0] xs = 0, ld = m_done;
    exp_t e;
    @(negedge clk);
    hv = v; hs = s; hd = d; hn = ns; hb = b; hl = l; hf = f; hc = nc;
    st_pend = sp; trap_done = td;
    for (int i = 0; i < W; i++) hq[i*SEQ_W +: SEQ_W] = base + SEQ_W'(i);
    for (int i = 0; i < W; i++) begin
      if (stp) continue;
      if (!v[i]) stp = 1;
      else if (s[i]) ed[i] = 1;
      else if (!d[i]) begin
        stp = 1;
        if (ns[i] | b[i]) begin
          if (n == 0 && !sp) begin xv = 1; xs = base + SEQ_W'(i); end
        end else if (l[i]) begin xv = 1; xu = 1; xs = base + SEQ_W'(i); end
      end else if (f[i]) begin
        stp = 1;
        if (n == 0 && !sp) tr = 1;
      end else begin
        ec[i] = 1; n++; ld = base + SEQ_W'(i);
        if (!nc[i]) add++;
      end
    end
    m_done = ld;
    m_ic = (int'(m_ic) + add > int'(MAXC)) ? MAXC : m_ic + CNT_W'(add);
    if (n == W && m_bc != MAXC) m_bc = m_bc + 1'b1;
    m_pend = tr ? 1'b1 : (td ? 1'b0 : m_pend);
    e.dseq = m_done; e.xv = xv; e.xs = xs; e.xu = xu; e.tr = tr; e.tp = m_pend;
    e.ic = m_ic; e.bc = m_bc; e.tag = 0;
    q.push_back(e);
    #3;
    ck({r, " commit"}, 64'(rt_commit), 64'(ec));
    ck({r, " drop"}, 64'(rt_drop), 64'(ed));
    ck({r, " rob_chg R2"}, 64'(rob_chg), 64'(|(ec | ed)));
  endtask

  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      ck("R6 done_seq", 64'(done_seq), 64'(e.dseq));
      ck("R3/R4 xreq_vld", 64'(xreq_vld), 64'(e.xv));
      if (e.xv) begin
        ck("R3/R4 xreq_seq", 64'(xreq_seq), 64'(e.xs));
        ck("R4 xreq_uncached", 64'(xreq_uncached), 64'(e.xu));
      end
      ck("R5 trap_req", 64'(trap_req), 64'(e.tr));
      ck("R5 trap_pend", 64'(trap_pend), 64'(e.tp));
      ck("R7/R9 inst_cnt", 64'(inst_cnt), 64'(e.ic));
      ck("R8/R9 bw_cnt", 64'(bw_cnt), 64'(e.bc));
    end
  end

  initial begin
    #200000;
    nbad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    ck("R10 done_seq", 64'(done_seq), 0);
    ck("R10 xreq", 64'(xreq_vld), 0);
    ck("R10 trap", 64'({trap_req, trap_pend}), 0);
    ck("R10 counters", 64'({inst_cnt, bw_cnt}), 0);
    @(negedge clk); rst_n = 1;
    // R1 R8 full width
    cyc("R1 full", 4'hF, 0, 4'hF, 0, 0, 0, 0, 0, 16'h0100, 0, 0);
    cyc("R1 partial", 4'h3, 0, 4'hF, 0, 0, 0, 0, 0, 16'h0110, 0, 0);
    cyc("R1 hole", 4'hD, 0, 4'hF, 0, 0, 0, 0, 0, 16'h0120, 0, 0);
    cyc("R1 unexec plain", 4'hF, 0, 4'hB, 0, 0, 0, 0, 0, 16'h0128, 0, 0);
    cyc("R6 idle", 4'h0, 0, 0, 0, 0, 0, 0, 0, 16'h0130, 0, 0);
    // R2 squashed
    cyc("R2 squash head", 4'hF, 4'h1, 4'hE, 0, 0, 0, 0, 0, 16'h0140, 0, 0);
    cyc("R2 squash mid", 4'hF, 4'h4, 4'hB, 0, 0, 0, 0, 0, 16'h0150, 0, 0);
    // R7 nocount
    cyc("R7 nop", 4'hF, 0, 4'hF, 0, 0, 0, 0, 4'h6, 16'h0160, 0, 0);
    // R3 nonspec / barrier
    cyc("R3 ns first", 4'hF, 0, 4'hE, 4'h1, 0, 0, 0, 0, 16'h0170, 0, 0);
    cyc("R3 ns second", 4'hF, 0, 4'hD, 4'h2, 0, 0, 0, 0, 16'h0180, 0, 0);
    cyc("R3 bar stores", 4'hF, 0, 4'hE, 0, 4'h1, 0, 0, 0, 16'h0190, 1, 0);
    cyc("R3 bar after drop", 4'hF, 4'h1, 4'hD, 0, 4'h2, 0, 0, 0, 16'h01A0, 0, 0);
    // R4 uncached load
    cyc("R4 load", 4'hF, 0, 4'hB, 0, 0, 4'h4, 0, 0, 16'h01B0, 1, 0);
    // R5 faults
    cyc("R5 fault second", 4'hF, 0, 4'hF, 0, 0, 0, 4'h2, 0, 16'h01C0, 0, 0);
    cyc("R5 fault stores", 4'hF, 0, 4'hF, 0, 0, 0, 4'h1, 0, 16'h01D0, 1, 0);
    cyc("R5 fault trap", 4'hF, 4'h1, 4'hF, 0, 0, 0, 4'h2, 0, 16'h01E0, 0, 0);
    cyc("R5 blocked", 4'hF, 4'h1, 4'hF, 0, 0, 0, 0, 0, 16'h01F0, 0, 0);
    cyc("R5 clear", 4'hF, 0, 4'hF, 0, 0, 0, 0, 0, 16'h0200, 0, 1);
    cyc("R5 resume", 4'hF, 0, 4'hF, 0, 0, 0, 0, 0, 16'h0210, 0, 0);
    // R9 saturation of both counters
    for (int k = 0; k < 70; k++)
      cyc("R9 sat", 4'hF, 0, 4'hF, 0, 0, 0, 0, 0, 16'h0300 + 16'(k*4), 0, 0);
    cyc("R9 hold", 4'hF, 0, 4'hF, 0, 0, 0, 0, 0, 16'hFFF0, 0, 0);
    @(negedge clk); hv = 0;
    repeat (3) @(posedge clk);
    #4;
    ck("R9 inst at max", 64'(inst_cnt), 64'(MAXC));
    ck("R9 bw at max", 64'(bw_cnt), 64'(MAXC));
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule